// File: doc/BRIEF.md
# Processor interrupt entry controller

This block decides, for a pipelined processor, in which cycle an external interrupt is accepted. When it accepts one, it asks the pipeline to redirect. The instruction already in execute is allowed to finish. The instruction in decode is squashed and replaced by a branch to the interrupt vector. That squashed instruction's PC is written into general purpose register 14 as the return address. After entry, the machine status logic clears its interrupt enable flag, and a later return-from-interrupt sets it again.

Two build-time parameters choose the variant. The first chooses how the input is sensed. With level sensing the input must stay high until it is taken. With edge sensing a rising edge is latched, and the latch fills whether or not interrupts are enabled. The second parameter chooses the vector. In the fixed-vector mode the target is a configured base address plus 0x10. In the fast vectored mode the interrupt controller supplies the handler address, and the block returns a two-bit acknowledge code to the controller.

Every output is registered. The acceptance decision is made at a clock edge, and the outputs of that decision are visible during the following cycle.

Top module: `irq_entry_ctrl`

## Requirements
- R1: An interrupt is accepted at a clock edge only if, at that edge, ie_i is 1, bip_i is 0 and eip_i is 0. With bip_i or eip_i high, or ie_i low, no redirect follows.
- R2: On acceptance, redirect_o and link_we_o are both 1 for exactly the one cycle after the accepting edge. At all other times both are 0.
- R3: While link_we_o is 1, link_addr_o equals the decode_pc_i value sampled at the accepting edge.
- R4: In fixed-vector mode (FAST_VECTOR=0), vector_o equals BASE_VECTOR + 0x10 while redirect_o is 1.
- R5: In fast vectored mode (FAST_VECTOR=1), an interrupt is accepted only while handler_valid_i is 1. While redirect_o is 1, vector_o equals the handler_addr_i sampled at the accepting edge.
- R6: In level mode (EDGE_SENSE=0), a request is present exactly while irq_i is 1. An input that is still high when the enable flag returns is taken again.
- R7: In edge mode (EDGE_SENSE=1), a single-cycle high pulse on irq_i is latched even while ie_i is 0. It is serviced once the enable flag becomes 1. The latch clears at the accepting edge, so each edge produces exactly one entry.
- R8: In edge mode, an irq_i held high produces no second entry. A new entry needs irq_i to be low for at least one sampled cycle and then high again.
- R9: In fast vectored mode, ack_o is 2'b01 in the cycle after an acceptance. It is 2'b10 in the cycle after a cycle in which rtid_i is 1 and no acceptance happened. Otherwise it is 2'b00. In fixed-vector mode ack_o is always 2'b00.
- R10: While rst_ni is low, every output is 0 and the edge latch is empty.
- R11: No acceptance happens at an edge where redirect_o is already 1. This prevents a second entry while the enable flag is still being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | External interrupt request line |
| handler_addr_i | input | ADDR_W | Handler address from the interrupt controller (fast mode) |
| handler_valid_i | input | 1 | handler_addr_i is valid (fast mode) |
| ie_i | input | 1 | Interrupt enable flag from machine status |
| bip_i | input | 1 | Break-in-progress flag |
| eip_i | input | 1 | Exception-in-progress flag |
| decode_pc_i | input | ADDR_W | PC of the instruction in decode |
| rtid_i | input | 1 | Return-from-interrupt is executing |
| redirect_o | output | 1 | Pipeline redirect request, one-cycle pulse |
| vector_o | output | ADDR_W | Redirect target |
| link_addr_o | output | ADDR_W | Return address for register 14 |
| link_we_o | output | 1 | Write enable for register 14 |
| ack_o | output | 2 | Acknowledge code to the interrupt controller |

## Verification
The assertions assume that the machine status logic around the block behaves correctly. In particular, ie_i must read 0 from the cycle after a redirect until a return-from-interrupt or a software enable sets it again. Without that, a level request would be re-entered as soon as the guard cycle ends.

The bench meets this assumption by modelling the status register itself for each instance. It clears the model's enable when redirect_o is seen and sets it on rtid_i or on a random software-enable strobe. The random stimulus toggles irq_i, the status flags, handler validity, the addresses and the return strobe under that rule. Directed phases place edge pulses while the enable is low, hold inputs high across re-enables, and keep requests blocked by the break flag.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE   = 2'b00,
    ACK_TAKEN  = 2'b01,
    ACK_RETURN = 2'b10
  } irq_ack_e;

  localparam int unsigned VEC_OFFSET = 16;
endpackage

// File: rtl/irq_req_detect.sv
module irq_req_detect #(
  parameter bit EDGE_SENSE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic take_i,
  output logic req_o
);
  generate
    if (EDGE_SENSE) begin : g_edge
      logic irq_q, pend_q, rise;
      assign rise  = irq_i & ~irq_q;
      // a live edge counts at once, so edge mode costs no extra cycle
      assign req_o = pend_q | rise;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          irq_q  <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          irq_q <= irq_i;
          if (take_i)    pend_q <= 1'b0;
          else if (rise) pend_q <= 1'b1;
        end
      end
    end else begin : g_level
      assign req_o = irq_i;
    end
  endgenerate
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter bit FAST_VECTOR = 1'b0
) (
  input  logic req_i,
  input  logic ie_i,
  input  logic bip_i,
  input  logic eip_i,
  input  logic busy_i,
  input  logic handler_valid_i,
  output logic take_o
);
  logic addr_ok;
  generate
    if (FAST_VECTOR) begin : g_fast
      assign addr_ok = handler_valid_i;
    end else begin : g_fixed
      assign addr_ok = 1'b1;
    end
  endgenerate

  assign take_o = req_i & ie_i & ~bip_i & ~eip_i & ~busy_i & addr_ok;
endmodule

// File: rtl/irq_redirect_regs.sv
module irq_redirect_regs
  import irq_entry_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_VECTOR = '0,
  parameter bit                FAST_VECTOR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              rtid_i,
  input  logic [ADDR_W-1:0] decode_pc_i,
  input  logic [ADDR_W-1:0] handler_addr_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [ADDR_W-1:0] link_addr_o,
  output logic              link_we_o,
  output logic [1:0]        ack_o
);
  localparam logic [ADDR_W-1:0] FIXED_VEC = BASE_VECTOR + ADDR_W'(VEC_OFFSET);

  logic [ADDR_W-1:0] vec_d;
  irq_ack_e          ack_d;

  generate
    if (FAST_VECTOR) begin : g_fast
      assign vec_d = handler_addr_i;
      always_comb begin
        if (take_i)      ack_d = ACK_TAKEN;
        else if (rtid_i) ack_d = ACK_RETURN;
        else             ack_d = ACK_IDLE;
      end
    end else begin : g_fixed
      assign vec_d = FIXED_VEC;
      assign ack_d = ACK_IDLE;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o  <= 1'b0;
      link_we_o   <= 1'b0;
      vector_o    <= '0;
      link_addr_o <= '0;
      ack_o       <= ACK_IDLE;
    end else begin
      redirect_o <= take_i;
      link_we_o  <= take_i;
      ack_o      <= ack_d;
      if (take_i) begin
        vector_o    <= vec_d;
        link_addr_o <= decode_pc_i;
      end
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int unsigned       ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_VECTOR = '0,
  parameter bit                EDGE_SENSE  = 1'b0,
  parameter bit                FAST_VECTOR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic [ADDR_W-1:0] handler_addr_i,
  input  logic              handler_valid_i,
  input  logic              ie_i,
  input  logic              bip_i,
  input  logic              eip_i,
  input  logic [ADDR_W-1:0] decode_pc_i,
  input  logic              rtid_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [ADDR_W-1:0] link_addr_o,
  output logic              link_we_o,
  output logic [1:0]        ack_o
);
  logic req, take;

  irq_req_detect #(.EDGE_SENSE(EDGE_SENSE)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .take_i (take),
    .req_o  (req)
  );

  // redirect_o marks the cycle in which status logic is still clearing ie
  irq_gate #(.FAST_VECTOR(FAST_VECTOR)) u_gate (
    .req_i           (req),
    .ie_i            (ie_i),
    .bip_i           (bip_i),
    .eip_i           (eip_i),
    .busy_i          (redirect_o),
    .handler_valid_i (handler_valid_i),
    .take_o          (take)
  );

  irq_redirect_regs #(
    .ADDR_W      (ADDR_W),
    .BASE_VECTOR (BASE_VECTOR),
    .FAST_VECTOR (FAST_VECTOR)
  ) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .take_i         (take),
    .rtid_i         (rtid_i),
    .decode_pc_i    (decode_pc_i),
    .handler_addr_i (handler_addr_i),
    .redirect_o     (redirect_o),
    .vector_o       (vector_o),
    .link_addr_o    (link_addr_o),
    .link_we_o      (link_we_o),
    .ack_o          (ack_o)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int unsigned       ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_VECTOR = '0,
  parameter bit                EDGE_SENSE  = 1'b0,
  parameter bit                FAST_VECTOR = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic [ADDR_W-1:0] handler_addr_i,
  input logic              handler_valid_i,
  input logic              ie_i,
  input logic              bip_i,
  input logic              eip_i,
  input logic [ADDR_W-1:0] decode_pc_i,
  input logic              rtid_i,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic [ADDR_W-1:0] link_addr_o,
  input logic              link_we_o,
  input logic [1:0]        ack_o
);
  logic seen_edge_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_edge_q <= 1'b0;
    else         seen_edge_q <= 1'b1;
  end

  assert_gate_flags_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_edge_q && redirect_o |-> $past(ie_i && !bip_i && !eip_i));

  assert_pulse_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o == link_we_o);

  assert_link_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_edge_q && link_we_o |-> link_addr_o == $past(decode_pc_i));

  assert_no_back_to_back_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  generate
    if (FAST_VECTOR) begin : g_fast
      assert_fast_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_edge_q && redirect_o |-> vector_o == $past(handler_addr_i) && $past(handler_valid_i));
      assert_ack_taken_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> ack_o == 2'b01);
      assert_ack_return_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rtid_i && !redirect_o |=> ack_o != 2'b00);
    end else begin : g_fixed
      assert_fixed_vector_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> vector_o == BASE_VECTOR + ADDR_W'(16));
      assert_ack_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o == 2'b00);
    end
    if (!EDGE_SENSE) begin : g_level
      assert_level_needs_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_edge_q && redirect_o |-> $past(irq_i));
    end
  endgenerate

  always_comb begin
    if (!rst_ni) begin
      assert_reset_outputs_R10: assert (!redirect_o && !link_we_o && ack_o == 2'b00);
    end
  end
endmodule

bind irq_entry_ctrl irq_entry_chk #(
  .ADDR_W      (ADDR_W),
  .BASE_VECTOR (BASE_VECTOR),
  .EDGE_SENSE  (EDGE_SENSE),
  .FAST_VECTOR (FAST_VECTOR)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .irq_i           (irq_i),
  .handler_addr_i  (handler_addr_i),
  .handler_valid_i (handler_valid_i),
  .ie_i            (ie_i),
  .bip_i           (bip_i),
  .eip_i           (eip_i),
  .decode_pc_i     (decode_pc_i),
  .rtid_i          (rtid_i),
  .redirect_o      (redirect_o),
  .vector_o        (vector_o),
  .link_addr_o     (link_addr_o),
  .link_we_o       (link_we_o),
  .ack_o           (ack_o)
);

// File: tb/irq_entry_ctrl_bench.sv
module irq_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [AW-1:0] BASE_A = 32'h0000_1000;
  localparam logic [AW-1:0] BASE_B = 32'h0000_8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq = 0, hv = 0, bip = 0, eip = 0, rtid = 0, sw_en = 0;
  logic [AW-1:0] haddr = '0, pc = '0;
  logic ie_a, ie_b;

  // A: level sensing, fixed vector. B: edge sensing, fast vectored.
  logic          red_a, we_a, red_b, we_b;
  logic [AW-1:0] vec_a, lnk_a, vec_b, lnk_b;
  logic [1:0]    ack_a, ack_b;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_ctrl #(.ADDR_W(AW), .BASE_VECTOR(BASE_A), .EDGE_SENSE(1'b0), .FAST_VECTOR(1'b0)) u_irq_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .handler_addr_i(haddr), .handler_valid_i(hv),
    .ie_i(ie_a), .bip_i(bip), .eip_i(eip), .decode_pc_i(pc), .rtid_i(rtid),
    .redirect_o(red_a), .vector_o(vec_a), .link_addr_o(lnk_a), .link_we_o(we_a), .ack_o(ack_a));

  irq_entry_ctrl #(.ADDR_W(AW), .BASE_VECTOR(BASE_B), .EDGE_SENSE(1'b1), .FAST_VECTOR(1'b1)) u_irq_entry_ctrl_ef (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .handler_addr_i(haddr), .handler_valid_i(hv),
    .ie_i(ie_b), .bip_i(bip), .eip_i(eip), .decode_pc_i(pc), .rtid_i(rtid),
    .redirect_o(red_b), .vector_o(vec_b), .link_addr_o(lnk_b), .link_we_o(we_b), .ack_o(ack_b));

  // expected-value model from the requirements
  function automatic logic take_fn(input logic edge_m, input logic fast_m, input logic pend,
                                   input logic irq_prev, input logic ie, input logic busy);
    logic req;
    req = edge_m ? (pend | (irq & ~irq_prev)) : irq;
    return req & ie & ~bip & ~eip & ~busy & (fast_m ? hv : 1'b1);
  endfunction

  function automatic logic [1:0] ack_fn(input logic fast_m, input logic tk);
    if (!fast_m) return 2'b00;
    if (tk)      return 2'b01;
    if (rtid)    return 2'b10;
    return 2'b00;
  endfunction

  logic          m_red_a, m_red_b, m_pend_b, m_prev_b;
  logic [AW-1:0] m_vec_a, m_lnk_a, m_vec_b, m_lnk_b;
  logic [1:0]    m_ack_a, m_ack_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_red_a <= 0; m_vec_a <= '0; m_lnk_a <= '0; m_ack_a <= 0; ie_a <= 0;
      m_red_b <= 0; m_vec_b <= '0; m_lnk_b <= '0; m_ack_b <= 0; ie_b <= 0;
      m_pend_b <= 0; m_prev_b <= 0;
    end else begin
      logic ta, tb;
      ta = take_fn(1'b0, 1'b0, 1'b0, 1'b0, ie_a, m_red_a);
      tb = take_fn(1'b1, 1'b1, m_pend_b, m_prev_b, ie_b, m_red_b);
      m_red_a <= ta; m_ack_a <= ack_fn(1'b0, ta);
      if (ta) begin m_vec_a <= BASE_A + 32'h10; m_lnk_a <= pc; end
      m_red_b <= tb; m_ack_b <= ack_fn(1'b1, tb);
      if (tb) begin m_vec_b <= haddr; m_lnk_b <= pc; end
      m_prev_b <= irq;
      if (tb) m_pend_b <= 1'b0;
      else if (irq & ~m_prev_b) m_pend_b <= 1'b1;
      // status-register model: redirect clears enable, return or software sets it
      ie_a <= red_a ? 1'b0 : ((rtid | sw_en) ? 1'b1 : ie_a);
      ie_b <= red_b ? 1'b0 : ((rtid | sw_en) ? 1'b1 : ie_b);
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic compare_on = 0;
  always @(negedge clk) if (rst_n && compare_on) begin
    chk(red_a == m_red_a, "R1 R2 R6 R11 redirect A", AW'(red_a), AW'(m_red_a));
    chk(we_a == m_red_a, "R2 link_we A", AW'(we_a), AW'(m_red_a));
    if (m_red_a) chk(lnk_a == m_lnk_a, "R3 link_addr A", lnk_a, m_lnk_a);
    if (m_red_a) chk(vec_a == m_vec_a, "R4 vector A", vec_a, m_vec_a);
    chk(ack_a == m_ack_a, "R9 ack A", AW'(ack_a), AW'(m_ack_a));
    chk(red_b == m_red_b, "R1 R2 R5 R7 R8 R11 redirect B", AW'(red_b), AW'(m_red_b));
    chk(we_b == m_red_b, "R2 link_we B", AW'(we_b), AW'(m_red_b));
    if (m_red_b) chk(lnk_b == m_lnk_b, "R3 link_addr B", lnk_b, m_lnk_b);
    if (m_red_b) chk(vec_b == m_vec_b, "R5 vector B", vec_b, m_vec_b);
    chk(ack_b == m_ack_b, "R9 ack B", AW'(ack_b), AW'(m_ack_b));
  end

  task automatic count_cycles(input int n, output int ca, output int cb);
    ca = 0; cb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca += int'(red_a);
      cb += int'(red_b);
    end
  endtask

  task automatic pulse_rtid();
    rtid = 1; @(negedge clk); rtid = 0;
  endtask

  task automatic pulse_sw();
    sw_en = 1; @(negedge clk); sw_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int ca, cb;
    void'($urandom(32'd20240611));
    irq = 1; // held high through reset: edge latch must stay empty
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!red_a && !we_a && ack_a == 0 && vec_a == 0 && lnk_a == 0, "R10 reset A", AW'(red_a), '0);
    chk(!red_b && !we_b && ack_b == 0 && vec_b == 0 && lnk_b == 0, "R10 reset B", AW'(red_b), '0);
    irq = 0;
    @(negedge clk);
    rst_n = 1;
    compare_on = 1;
    hv = 1; haddr = 32'hCAFE_0040; pc = 32'h0000_0200;
    @(negedge clk);

    // R7: edge pulse latched while enable low, served after enable
    irq = 1; @(negedge clk); irq = 0;
    count_cycles(4, ca, cb);
    chk(cb == 0, "R7 no entry while disabled", AW'(cb), 0);
    pulse_sw();
    count_cycles(6, ca, cb);
    chk(cb == 1, "R7 latched edge served once", AW'(cb), 1);

    // R8/R6: held-high input
    pulse_rtid();
    irq = 1; pc = 32'h0000_0300;
    count_cycles(10, ca, cb);
    chk(ca == 1, "R6 level taken once", AW'(ca), 1);
    chk(cb == 1, "R8 held edge taken once", AW'(cb), 1);
    pulse_rtid();
    count_cycles(6, ca, cb);
    chk(ca == 1, "R6 level retaken after return", AW'(ca), 1);
    chk(cb == 0, "R8 no entry without new edge", AW'(cb), 0);
    irq = 0; @(negedge clk); irq = 1;
    count_cycles(6, ca, cb);
    chk(cb == 1, "R8 entry after low cycle", AW'(cb), 1);

    // R1: break flag blocks a level request
    irq = 0; @(negedge clk);
    pulse_sw();
    bip = 1; irq = 1;
    count_cycles(5, ca, cb);
    chk(ca == 0, "R1 blocked by break flag", AW'(ca), 0);
    bip = 0;
    count_cycles(5, ca, cb);
    chk(ca == 1, "R1 taken after flag drops", AW'(ca), 1);
    irq = 0; eip = 1; @(negedge clk); pulse_sw(); irq = 1;
    count_cycles(4, ca, cb);
    chk(ca == 0 && cb == 0, "R1 blocked by exception flag", AW'(ca + cb), 0);
    eip = 0; irq = 0; hv = 0;
    count_cycles(4, ca, cb);
    chk(cb == 0, "R5 no fast entry without valid address", AW'(cb), 0);
    hv = 1;
    count_cycles(4, ca, cb);
    chk(cb == 1, "R5 fast entry once address valid", AW'(cb), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      irq   = ($urandom_range(0, 3) == 0) ? ~irq : irq;
      hv    = $urandom_range(0, 3) != 0;
      bip   = $urandom_range(0, 9) == 0;
      eip   = $urandom_range(0, 9) == 0;
      rtid  = $urandom_range(0, 11) == 0;
      sw_en = $urandom_range(0, 15) == 0;
      pc    = $urandom;
      haddr = $urandom;
      @(negedge clk);
    end
    rtid = 0; sw_en = 0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule